// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a small two-way set-associative read cache that sits between a processor read port and a slower next-level memory. Each set keeps a single prediction bit that names the way expected to hit. A lookup first examines only that way. The output data multiplexer is already steered by the prediction before the tag result is known, so a correct guess returns the word one cycle after the request is taken.

When the guess is wrong, the other way is compared in the following cycle. A hit found there is returned three cycles after acceptance, and the set's prediction is moved to that way. When neither way holds the line, the word is fetched from the next-level port and written into a free way, or into the least recently used way when both are full. The word is then handed to the processor.

Three counters separate predicted hits, mispredicted hits and misses, so the split between the latency classes can be observed from outside. The processor port accepts one request at a time. It takes no new request until the current one has been answered.

Top module: `wpc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, all three counters read 0, every entry is invalid (the first access to any address misses), and every set's prediction names way 0.
- R2: An address splits into a 2-bit byte offset at bits [1:0], a set index in the next log2(SETS) bits, and a tag in the remaining upper bits. The offset bits have no effect on hit or miss or on the data returned.
- R3: An entry hits only when its valid bit is set and its stored tag equals the address tag. When the predicted way hits, `rsp_valid` is high with that way's word in the first cycle after the accepting edge.
- R4: When the predicted way misses and the other way hits, the response comes in the third cycle after acceptance. The set's prediction then names the way that hit, so an immediate repeat of that access answers in one cycle.
- R5: On a miss in both ways, `mem_req_valid` rises in the third cycle after acceptance. `mem_req_addr` carries the request address with bits [1:0] cleared and stays stable until `mem_rsp_valid` is seen. The response follows in the cycle after `mem_rsp_valid`, carrying `mem_rsp_data`.
- R6: A refill goes to an invalid way if there is one (way 0 before way 1). Otherwise it goes to the way used least recently, where every hit or refill counts as a use. The set's prediction then names the refilled way.
- R7: `req_ready` is 0 from the accepting edge through the response cycle, and it is 1 again in the cycle after the response.
- R8: `cnt_pred_hit`, `cnt_mispred_hit` and `cnt_miss` each count up by one for every access of their kind and for no other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Read word is valid this cycle |
| rsp_data | output | DATA_W | Read word |
| mem_req_valid | output | 1 | Refill request to next level |
| mem_req_addr | output | ADDR_W | Word-aligned refill address |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | DATA_W | Refill word |
| cnt_pred_hit | output | CNT_W | Number of hits in the predicted way |
| cnt_mispred_hit | output | CNT_W | Number of hits in the other way |
| cnt_miss | output | CNT_W | Number of misses in both ways |

## Verification
The bench builds the cache with an 8-bit address, four sets and 16-bit words, which leaves a 4-bit tag. Holding most traffic to four tags per set makes predicted hits, mispredicted hits, fills into free ways and least-recently-used evictions all occur often. A further pass walks all 256 byte addresses, including every offset. Refill delays cycle from zero to three wait cycles, and the bench's own set model predicts the latency class, data and counter totals of every access.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_ALT,
    ST_ALT_RSP,
    ST_REFILL,
    ST_FILL_RSP
  } wpc_state_e;

  // Replacement choice: first free way (way 0 first), else the LRU way.
  function automatic logic pick_victim(input logic [1:0] way_valid,
                                       input logic lru_way);
    if (!way_valid[0]) return 1'b0;
    if (!way_valid[1]) return 1'b1;
    return lru_way;
  endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  output logic [1:0]              rd_valid,
  output logic [1:0][TAG_W-1:0]   rd_tag,
  output logic                    rd_pred,
  output logic                    rd_lru,
  input  logic                    fill_en,
  input  logic                    fill_way,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic                    pred_en,
  input  logic                    pred_way,
  input  logic                    touch_en,
  input  logic                    touch_way
);

  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
      end else if (fill_en && (fill_way == w[0])) begin
        valid_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == w[0])) begin
        tag_q[idx] <= fill_tag;
      end
    end

    assign rd_valid[w] = valid_q[idx];
    assign rd_tag[w]   = tag_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else begin
      if (pred_en)  pred_q[idx] <= pred_way;
      if (touch_en) lru_q[idx]  <= ~touch_way;
    end
  end

  assign rd_pred = pred_q[idx];
  assign rd_lru  = lru_q[idx];

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sel_way,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0][DATA_W-1:0] way_word;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) begin
        mem_q[idx] <= wr_data;
      end
    end

    assign way_word[w] = mem_q[idx];
  end

  // Output mux steered by the selector, independent of any tag result.
  assign rd_data = way_word[sel_way];

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       pred_match,
  input  logic       alt_match,
  input  logic       mem_rsp_valid,
  output wpc_state_e state
);

  wpc_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:     if (req_valid)     state_d = ST_PROBE;
      ST_PROBE:    state_d = pred_match ? ST_IDLE : ST_ALT;
      ST_ALT:      state_d = alt_match ? ST_ALT_RSP : ST_REFILL;
      ST_ALT_RSP:  state_d = ST_IDLE;
      ST_REFILL:   if (mem_rsp_valid) state_d = ST_FILL_RSP;
      ST_FILL_RSP: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_pred_hit,
  output logic [CNT_W-1:0]  cnt_mispred_hit,
  output logic [CNT_W-1:0]  cnt_miss
);

  localparam int OFS_W = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << OFS_W) - 1);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  wpc_state_e              state;
  logic [ADDR_W-1:0]       addr_q;
  logic [IDX_W-1:0]        cur_idx;
  logic [TAG_W-1:0]        cur_tag;
  logic [1:0]              rd_valid;
  logic [1:0][TAG_W-1:0]   rd_tag;
  logic                    rd_pred;
  logic                    rd_lru;
  logic                    pred_way;
  logic                    alt_way;
  logic                    pred_match;
  logic                    alt_match;
  logic                    victim;
  logic                    way_q;
  logic                    sel_way;
  logic                    req_fire;

  // Named internal events, also observed by the checker.
  logic ev_pred_hit;
  logic ev_alt_hit;
  logic ev_miss;
  logic ev_fill;

  assign req_fire   = req_valid && req_ready;
  assign cur_idx    = idx_of(addr_q);
  assign cur_tag    = tag_of(addr_q);
  assign pred_way   = rd_pred;
  assign alt_way    = ~rd_pred;
  assign pred_match = rd_valid[pred_way] && (rd_tag[pred_way] == cur_tag);
  assign alt_match  = rd_valid[alt_way]  && (rd_tag[alt_way]  == cur_tag);
  assign victim     = pick_victim(rd_valid, rd_lru);

  assign ev_pred_hit = (state == ST_PROBE)  && pred_match;
  assign ev_alt_hit  = (state == ST_ALT)    && alt_match;
  assign ev_miss     = (state == ST_ALT)    && !alt_match;
  assign ev_fill     = (state == ST_REFILL) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (req_fire) addr_q <= req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          way_q <= 1'b0;
    else if (ev_alt_hit) way_q <= alt_way;
    else if (ev_fill)    way_q <= victim;
  end

  wpc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .pred_match    (pred_match),
    .alt_match     (alt_match),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state)
  );

  wpc_tag_store #(
    .SETS  (SETS),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (cur_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_pred   (rd_pred),
    .rd_lru    (rd_lru),
    .fill_en   (ev_fill),
    .fill_way  (victim),
    .fill_tag  (cur_tag),
    .pred_en   (ev_alt_hit || ev_fill),
    .pred_way  (ev_fill ? victim : alt_way),
    .touch_en  (ev_pred_hit || ev_alt_hit || ev_fill),
    .touch_way (ev_pred_hit ? pred_way : (ev_alt_hit ? alt_way : victim))
  );

  // First cycle: mux follows the prediction; later cycles: the resolved way.
  assign sel_way = (state == ST_PROBE) ? pred_way : way_q;

  wpc_data_store #(
    .SETS   (SETS),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .idx     (cur_idx),
    .wr_en   (ev_fill),
    .wr_way  (victim),
    .wr_data (mem_rsp_data),
    .sel_way (sel_way),
    .rd_data (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_pred_hit    <= '0;
      cnt_mispred_hit <= '0;
      cnt_miss        <= '0;
    end else begin
      if (ev_pred_hit) cnt_pred_hit    <= cnt_pred_hit + CNT_W'(1);
      if (ev_alt_hit)  cnt_mispred_hit <= cnt_mispred_hit + CNT_W'(1);
      if (ev_miss)     cnt_miss        <= cnt_miss + CNT_W'(1);
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = ev_pred_hit || (state == ST_ALT_RSP) || (state == ST_FILL_RSP);
  assign mem_req_valid = (state == ST_REFILL);
  assign mem_req_addr  = addr_q & LINE_MASK;

endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [CNT_W-1:0]  cnt_pred_hit,
  input logic              ev_pred_hit,
  input logic              ev_alt_hit,
  input logic              ev_miss,
  input logic              ev_fill
);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  rsp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R4
  alt_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alt_hit |=> rsp_valid);

  // R5
  miss_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_req_valid);

  // R5
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R5
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> rsp_valid);

  // R8
  pred_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pred_hit |=> (cnt_pred_hit == $past(cnt_pred_hit) + CNT_W'(1)));

  // R3
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_pred_hit, ev_alt_hit, ev_miss, ev_fill}));

endmodule

bind wpc_cache wpc_cache_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .cnt_pred_hit  (cnt_pred_hit),
  .ev_pred_hit   (ev_pred_hit),
  .ev_alt_hit    (ev_alt_hit),
  .ev_miss       (ev_miss),
  .ev_fill       (ev_fill)
);

// File: tb/wpc_cache_test.sv
`timescale 1ns/1ps
module wpc_cache_test;

  localparam int AW = 8;
  localparam int NS = 4;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [CW-1:0] cnt_pred_hit, cnt_mispred_hit, cnt_miss;

  int checks = 0;
  int errors = 0;

  // Reference state per set, kept from the requirements.
  logic       m_valid [NS][2];
  logic [3:0] m_tag   [NS][2];
  logic       m_pred  [NS];
  logic       m_lru   [NS];
  int exp_ph = 0, exp_mh = 0, exp_ms = 0;

  always #5 clk = ~clk;

  wpc_cache #(.ADDR_W(AW), .SETS(NS), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cnt_pred_hit(cnt_pred_hit), .cnt_mispred_hit(cnt_mispred_hit),
    .cnt_miss(cnt_miss)
  );

  // Next-level content: word depends only on the aligned address.
  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [5:0] w;
    w = a[7:2];
    return {w ^ 6'h2A, 2'b01, w, 2'b10};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int delay);
    int idx, kind, exp_lat, lat, waited;
    logic [3:0] tg;
    logic p, o, v, sent;
    idx = int'(a[3:2]);
    tg  = a[7:4];
    p   = m_pred[idx];
    o   = ~p;
    if (m_valid[idx][p] && m_tag[idx][p] == tg) begin
      kind = 0; exp_lat = 1; m_lru[idx] = ~p; exp_ph++;
    end else if (m_valid[idx][o] && m_tag[idx][o] == tg) begin
      kind = 1; exp_lat = 3; m_pred[idx] = o; m_lru[idx] = p; exp_mh++;
    end else begin
      kind = 2; exp_lat = 4 + delay; exp_ms++;
      if (!m_valid[idx][0])      v = 1'b0;
      else if (!m_valid[idx][1]) v = 1'b1;
      else                       v = m_lru[idx];
      m_valid[idx][v] = 1'b1; m_tag[idx][v] = tg;
      m_pred[idx] = v; m_lru[idx] = ~v;
    end

    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    lat = 1; waited = 0; sent = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (rsp_valid) break;
      check(req_ready == 1'b0, "R7 ready low while busy", int'(req_ready), 0);
      if (mem_req_valid && !sent) begin
        if (waited == 0) begin
          check(kind == 2, "R5 refill only on miss", 1, kind == 2 ? 1 : 0);
          check(lat == 3, "R5 refill request cycle", lat, 3);
          check(mem_req_addr == (a & 8'hFC), "R5 refill address",
                int'(mem_req_addr), int'(a & 8'hFC));
        end
        if (waited == delay) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(mem_req_addr);
          sent = 1'b1;
        end else begin
          waited++;
        end
      end
      @(negedge clk);
      lat++;
    end
    case (kind)
      0: check(lat == exp_lat, "R3 predicted-hit latency", lat, exp_lat);
      1: check(lat == exp_lat, "R4 mispredicted-hit latency", lat, exp_lat);
      default: check(lat == exp_lat, "R6 miss latency and victim choice", lat, exp_lat);
    endcase
    check(rsp_data == mem_word(a), "R2 response data", int'(rsp_data), int'(mem_word(a)));
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready after response", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R7 single response cycle", int'(rsp_valid), 0);
  endtask

  task automatic check_counters(input string tag);
    check(int'(cnt_pred_hit) == exp_ph, {"R8 predicted-hit count ", tag}, int'(cnt_pred_hit), exp_ph);
    check(int'(cnt_mispred_hit) == exp_mh, {"R8 mispredicted-hit count ", tag}, int'(cnt_mispred_hit), exp_mh);
    check(int'(cnt_miss) == exp_ms, {"R8 miss count ", tag}, int'(cnt_miss), exp_ms);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rng;
    for (int s = 0; s < NS; s++) begin
      m_valid[s][0] = 1'b0; m_valid[s][1] = 1'b0;
      m_tag[s][0] = '0; m_tag[s][1] = '0;
      m_pred[s] = 1'b0; m_lru[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R1 no refill after reset", int'(mem_req_valid), 0);
    check_counters("R1 after reset");

    // Directed set 1 walk: fills, offsets, mispredict, LRU eviction.
    do_read(8'h14, 0);   // R1 cold miss, fill way 0
    do_read(8'h14, 0);   // R3 predicted hit
    do_read(8'h17, 0);   // R2 offset ignored
    do_read(8'h24, 1);   // R6 free way 1 chosen
    do_read(8'h25, 0);   // R3 hit on new prediction
    do_read(8'h16, 0);   // R4 mispredicted hit
    do_read(8'h14, 0);   // R4 prediction moved
    do_read(8'h34, 2);   // R6 LRU eviction
    do_read(8'h24, 3);   // R6 evicted line misses again
    do_read(8'h34, 0);   // R4 other way
    check_counters("after directed walk");

    // Near-exhaustive traffic over four tags per set.
    rng = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      do_read({2'b00, rng[5:0]}, i % 4);
    end
    check_counters("after mixed traffic");

    // Every byte address once, including all offsets.
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), a % 3);
    end
    check_counters("after full sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule